// File: doc/BRIEF.md
# Configuration Retry Status Handler

This block sits between a host-side configuration access port and the link-side request and completion path of a root port. It takes one configuration read or write at a time. On acceptance it captures the register address, write data, byte enables, the direction and the state of the software-visibility enable. It then presents the request to the link and classifies the completion that comes back.

A completion that carries configuration request retry status is never handed straight to the host. There are two cases where the block resolves it itself:

- With software visibility enabled, a read of register dword 0 returns a placeholder Vendor ID.
- In every other case, the block waits a programmable idle gap and sends the identical request again.

A programmable reissue limit bounds the loop. When the limit is used up, the host receives the retry status together with a dedicated indicator. The host sees a busy flag for the life of the transaction and one acknowledge pulse that carries the final status and read data.

Top module: `cfg_retry_ctrl`

## Requirements
- R1: After reset, `host_busy`, `host_ack`, `host_crs` and `lnk_req_valid` are all low.
- R2: A request on `host_req` is accepted only while `host_busy` is low. `host_busy` is high from the cycle after acceptance through the acknowledge cycle. A `host_req` raised while busy has no effect: no extra link request and no extra acknowledge.
- R3: `lnk_req_we`, `lnk_req_addr`, `lnk_req_wdata` and `lnk_req_be` equal the values captured at acceptance on every request, including reissues. They stay stable while `lnk_req_valid` is high and `lnk_req_ready` is low.
- R4: A completion whose 3-bit status is not 2 (0 = success, 1 = unsupported, 4 = abort) ends the transaction. `host_ack` is high for exactly one cycle, in the cycle after the completion. `host_status` equals the completion status. `host_rdata` equals the completion data for a read and is zero for a write. `host_crs` stays low.
- R5: With the visibility enable clear, a completion with status 2 (retry) causes the same request to be reissued.
- R6: With the visibility enable set, a read whose address has bits [11:2] all zero that completes with status 2 acknowledges with `host_rdata` = 0xFFFF0001, `host_status` = 0 and `host_crs` low. No reissue is sent.
- R7: With the visibility enable set, a retry completion for a write, or for a read of any other dword, is reissued.
- R8: Between a retry completion and its reissue, `lnk_req_valid` stays low for at least `idle_gap` cycles.
- R9: After `retry_limit` reissues, the next retry completion ends the transaction with `host_status` = 2 and `host_crs` high. `host_rdata` is 0xFFFFFFFF for a read and zero for a write.
- R10: `host_crs` is high only in a cycle where `host_ack` is high, and `host_ack` never lasts two cycles.
- R11: The visibility enable is sampled at acceptance only. Changing it later does not alter the handling of the current transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sv_enable | input | 1 | Software-visibility enable for retry status |
| retry_limit | input | CNT_W | Maximum number of reissues |
| idle_gap | input | GAP_W | Minimum idle cycles before each reissue |
| host_req | input | 1 | Start a configuration access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Register byte address |
| host_wdata | input | DATA_W | Write data |
| host_be | input | BE_W | Byte enables |
| host_busy | output | 1 | Transaction in progress |
| host_ack | output | 1 | One-cycle completion strobe |
| host_status | output | 3 | Final completion status |
| host_crs | output | 1 | Retry status indicator, with acknowledge only |
| host_rdata | output | DATA_W | Final read data |
| lnk_req_valid | output | 1 | Request presented to link |
| lnk_req_ready | input | 1 | Link takes the request |
| lnk_req_we | output | 1 | Request direction |
| lnk_req_addr | output | ADDR_W | Request address |
| lnk_req_wdata | output | DATA_W | Request write data |
| lnk_req_be | output | BE_W | Request byte enables |
| cpl_valid | input | 1 | Completion arrives |
| cpl_status | input | 3 | Completion status |
| cpl_data | input | DATA_W | Completion data |

## Verification
The assertions check these rules on every cycle:
- the retry indicator appears only with a single-cycle acknowledge, and agrees with the reported status;
- request fields stay frozen while the link stalls;
- a link request or an acknowledge never occurs outside a busy period.

The bench scenarios cover the rules that depend on a whole sequence:
- the choice between reissue and Vendor ID substitution under each enable and address combination;
- the idle gap before each reissue;
- exhaustion of the retry limit for reads and writes;
- immunity to a mid-transaction enable change or a stray host request.

// File: rtl/cfg_retry_pkg.sv
// Package: shared encodings for the configuration retry status handler.
// Assumes a 3-bit completion status field in which value 2 marks retry.
package cfg_retry_pkg;

    localparam logic [2:0] ST_SUCCESS = 3'd0;
    localparam logic [2:0] ST_RETRY   = 3'd2;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SEND,
        SQ_WAIT,
        SQ_GAP,
        SQ_RESP
    } seq_state_t;

    typedef enum logic [1:0] {
        OC_PASS,
        OC_SUBST,
        OC_RETRY,
        OC_GIVEUP
    } outcome_t;

endpackage

// File: rtl/cfg_req_hold.sv
// Module: captures a host configuration access at acceptance and holds it
// unchanged until the next acceptance. Also samples the software-visibility
// enable, so the current transaction ignores later changes to it.
// Assumes load is asserted only while the sequencer is idle.
module cfg_req_hold #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic              sv_i,
    output logic              we_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [BE_W-1:0]   be_q,
    output logic              sv_q
);

    // Capture the request fields and the visibility enable on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            sv_q    <= 1'b0;
        end else if (load) begin
            we_q    <= we_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            be_q    <= be_i;
            sv_q    <= sv_i;
        end
    end

endmodule

// File: rtl/cfg_cpl_classify.sv
// Module: combinational classifier for a returning completion. It decides
// between pass-through, Vendor ID substitution, reissue and give-up, and
// forms the response that goes to the host.
// Assumes the held request fields are stable while a completion is examined.
module cfg_cpl_classify #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic [2:0]                  cpl_status,
    input  logic [DATA_W-1:0]           cpl_data,
    input  logic                        we_q,
    input  logic [ADDR_W-1:0]           addr_q,
    input  logic                        sv_q,
    input  logic                        limit_hit,
    output cfg_retry_pkg::outcome_t     outcome,
    output logic [2:0]                  rsp_status,
    output logic [DATA_W-1:0]           rsp_data,
    output logic                        rsp_crs
);
    import cfg_retry_pkg::*;

    localparam int                FILL_W   = DATA_W - 16;
    localparam logic [DATA_W-1:0] VID_FILL = {{FILL_W{1'b1}}, 16'h0001};
    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    logic is_retry;
    logic vid_read;

    // Identify a retry completion and a read of register dword zero.
    always_comb begin
        is_retry = (cpl_status == ST_RETRY);
        vid_read = sv_q && !we_q && (addr_q[ADDR_W-1:2] == '0);
    end

    // Choose the outcome; substitution has priority over the retry limit.
    always_comb begin
        if (!is_retry) begin
            outcome = OC_PASS;
        end else if (vid_read) begin
            outcome = OC_SUBST;
        end else if (limit_hit) begin
            outcome = OC_GIVEUP;
        end else begin
            outcome = OC_RETRY;
        end
    end

    // Build the host-facing status, data and retry indicator for the outcome.
    always_comb begin
        rsp_status = cpl_status;
        rsp_data   = '0;
        rsp_crs    = 1'b0;
        unique case (outcome)
            OC_PASS: begin
                rsp_data = we_q ? '0 : cpl_data;
            end
            OC_SUBST: begin
                rsp_status = ST_SUCCESS;
                rsp_data   = VID_FILL;
            end
            OC_GIVEUP: begin
                rsp_status = ST_RETRY;
                rsp_data   = we_q ? '0 : ALL_ONES;
                rsp_crs    = 1'b1;
            end
            default: begin
                rsp_data = '0;
            end
        endcase
    end

endmodule

// File: rtl/cfg_retry_fsm.sv
// Module: sequencer for one configuration transaction. It presents the
// request, waits for the completion, inserts the idle gap before each
// reissue, counts reissues against the limit and raises the response state.
// Assumes a single outstanding request and at most one completion for it.
module cfg_retry_fsm #(
    parameter int CNT_W = 8,
    parameter int GAP_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          accept,
    input  logic                          lnk_req_ready,
    input  logic                          cpl_valid,
    input  cfg_retry_pkg::outcome_t       outcome,
    input  logic [CNT_W-1:0]              retry_limit,
    input  logic [GAP_W-1:0]              idle_gap,
    output cfg_retry_pkg::seq_state_t     state_q,
    output logic                          limit_hit,
    output logic                          finish
);
    import cfg_retry_pkg::*;

    seq_state_t       state_d;
    logic [CNT_W-1:0] tries_q;
    logic [GAP_W-1:0] gap_q;
    logic             reissue;

    // Flag the limit and the two ways a completion is consumed.
    always_comb begin
        limit_hit = (tries_q == retry_limit);
        reissue   = (state_q == SQ_WAIT) && cpl_valid && (outcome == OC_RETRY);
        finish    = (state_q == SQ_WAIT) && cpl_valid && (outcome != OC_RETRY);
    end

    // Next-state selection for the transaction sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: if (accept)               state_d = SQ_SEND;
            SQ_SEND: if (lnk_req_ready)        state_d = SQ_WAIT;
            SQ_WAIT: begin
                if (finish)                    state_d = SQ_RESP;
                else if (reissue)              state_d = SQ_GAP;
            end
            SQ_GAP:  if (gap_q == '0)          state_d = SQ_SEND;
            SQ_RESP:                           state_d = SQ_IDLE;
            default:                           state_d = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // Reissue counter: cleared at acceptance, advanced on each reissue.
    always_ff @(posedge clk) begin
        if (!rst_n)       tries_q <= '0;
        else if (accept)  tries_q <= '0;
        else if (reissue) tries_q <= tries_q + 1'b1;
    end

    // Idle gap counter: loaded on a reissue decision, counted down in GAP.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   gap_q <= '0;
        else if (reissue)                             gap_q <= idle_gap;
        else if (state_q == SQ_GAP && gap_q != '0)    gap_q <= gap_q - 1'b1;
    end

endmodule

// File: rtl/cfg_retry_ctrl.sv
// Module: top of the configuration retry status handler. It joins the
// request holder, the completion classifier and the sequencer, and
// registers the host response so that status and data stay steady.
// Assumes the link returns exactly one completion per accepted request.
module cfg_retry_ctrl #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8,
    parameter int CNT_W  = 8,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sv_enable,
    input  logic [CNT_W-1:0]  retry_limit,
    input  logic [GAP_W-1:0]  idle_gap,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [BE_W-1:0]   host_be,
    output logic              host_busy,
    output logic              host_ack,
    output logic [2:0]        host_status,
    output logic              host_crs,
    output logic [DATA_W-1:0] host_rdata,
    output logic              lnk_req_valid,
    input  logic              lnk_req_ready,
    output logic              lnk_req_we,
    output logic [ADDR_W-1:0] lnk_req_addr,
    output logic [DATA_W-1:0] lnk_req_wdata,
    output logic [BE_W-1:0]   lnk_req_be,
    input  logic              cpl_valid,
    input  logic [2:0]        cpl_status,
    input  logic [DATA_W-1:0] cpl_data
);
    import cfg_retry_pkg::*;

    seq_state_t        state_q;
    outcome_t          outcome;
    logic              accept;
    logic              limit_hit;
    logic              finish;
    logic              sv_q;
    logic [2:0]        rsp_status;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_crs;
    logic              crs_q;

    // Accept a host access only when no transaction is in flight.
    always_comb begin
        accept = host_req && (state_q == SQ_IDLE);
    end

    cfg_req_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .we_i    (host_we),
        .addr_i  (host_addr),
        .wdata_i (host_wdata),
        .be_i    (host_be),
        .sv_i    (sv_enable),
        .we_q    (lnk_req_we),
        .addr_q  (lnk_req_addr),
        .wdata_q (lnk_req_wdata),
        .be_q    (lnk_req_be),
        .sv_q    (sv_q)
    );

    cfg_cpl_classify #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cls (
        .cpl_status (cpl_status),
        .cpl_data   (cpl_data),
        .we_q       (lnk_req_we),
        .addr_q     (lnk_req_addr),
        .sv_q       (sv_q),
        .limit_hit  (limit_hit),
        .outcome    (outcome),
        .rsp_status (rsp_status),
        .rsp_data   (rsp_data),
        .rsp_crs    (rsp_crs)
    );

    cfg_retry_fsm #(
        .CNT_W (CNT_W),
        .GAP_W (GAP_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept        (accept),
        .lnk_req_ready (lnk_req_ready),
        .cpl_valid     (cpl_valid),
        .outcome       (outcome),
        .retry_limit   (retry_limit),
        .idle_gap      (idle_gap),
        .state_q       (state_q),
        .limit_hit     (limit_hit),
        .finish        (finish)
    );

    // Register the final response when the transaction completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_status <= ST_SUCCESS;
            host_rdata  <= '0;
            crs_q       <= 1'b0;
        end else if (finish) begin
            host_status <= rsp_status;
            host_rdata  <= rsp_data;
            crs_q       <= rsp_crs;
        end
    end

    // Drive host handshake and link valid from the sequencer state.
    always_comb begin
        host_busy     = (state_q != SQ_IDLE);
        host_ack      = (state_q == SQ_RESP);
        host_crs      = host_ack && crs_q;
        lnk_req_valid = (state_q == SQ_SEND);
    end

endmodule

// File: rtl/cfg_retry_chk.sv
// Module: assertion checker for cfg_retry_ctrl, attached by bind.
// Assumes the same parameters as the top module it observes.
module cfg_retry_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_busy,
    input logic              host_ack,
    input logic              host_crs,
    input logic [2:0]        host_status,
    input logic              lnk_req_valid,
    input logic              lnk_req_ready,
    input logic              lnk_req_we,
    input logic [ADDR_W-1:0] lnk_req_addr,
    input logic [DATA_W-1:0] lnk_req_wdata,
    input logic [BE_W-1:0]   lnk_req_be
);

    AST_CRS_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        host_crs |-> host_ack);                                   // R10
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);                                  // R10
    AST_CRS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (host_crs == (host_status == 3'd2)));        // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req_valid && !lnk_req_ready) |=> (lnk_req_valid
            && $stable(lnk_req_addr) && $stable(lnk_req_wdata)
            && $stable(lnk_req_be) && $stable(lnk_req_we)));      // R3
    AST_LINK_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_req_valid |-> host_busy);                             // R2
    AST_ACK_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> host_busy);                                  // R2

endmodule

bind cfg_retry_ctrl cfg_retry_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_busy     (host_busy),
    .host_ack      (host_ack),
    .host_crs      (host_crs),
    .host_status   (host_status),
    .lnk_req_valid (lnk_req_valid),
    .lnk_req_ready (lnk_req_ready),
    .lnk_req_we    (lnk_req_we),
    .lnk_req_addr  (lnk_req_addr),
    .lnk_req_wdata (lnk_req_wdata),
    .lnk_req_be    (lnk_req_be)
);

// File: tb/sim_cfg_retry_ctrl.sv
// Directed bench for cfg_retry_ctrl: one task per scenario, with a link
// responder that returns a programmed series of completion statuses.
module sim_cfg_retry_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int GAP_CFG    = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sv_enable = 1'b0;
    logic [7:0]  retry_limit = 8'd5;
    logic [7:0]  idle_gap = 8'(GAP_CFG);
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_be = '0;
    logic        host_busy, host_ack, host_crs;
    logic [2:0]  host_status;
    logic [31:0] host_rdata;
    logic        lnk_req_valid;
    logic        lnk_req_ready = 1'b0;
    logic        lnk_req_we;
    logic [11:0] lnk_req_addr;
    logic [31:0] lnk_req_wdata;
    logic [3:0]  lnk_req_be;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_status = '0;
    logic [31:0] cpl_data = '0;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_retry_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sv_enable(sv_enable),
        .retry_limit(retry_limit), .idle_gap(idle_gap),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_be(host_be),
        .host_busy(host_busy), .host_ack(host_ack),
        .host_status(host_status), .host_crs(host_crs),
        .host_rdata(host_rdata),
        .lnk_req_valid(lnk_req_valid), .lnk_req_ready(lnk_req_ready),
        .lnk_req_we(lnk_req_we), .lnk_req_addr(lnk_req_addr),
        .lnk_req_wdata(lnk_req_wdata), .lnk_req_be(lnk_req_be),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data)
    );

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                 n_checks, n_fails);
    endtask

    // Wait for a link request; return how many low cycles were seen.
    task automatic wait_valid(output int waited);
        waited = 0;
        while (!lnk_req_valid && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    // Full transaction: host issue, link service of n_req requests with the
    // first n_crs answered as retry, then check of the host response.
    task automatic run_txn(input string tag, input bit we,
            input logic [11:0] addr, input logic [31:0] wd,
            input logic [3:0] be, input bit sv, input bit sv_flip,
            input bit poke, input int n_req, input int n_crs,
            input logic [2:0] fin_st, input logic [31:0] fin_data,
            input logic [2:0] exp_st, input bit exp_crs,
            input logic [31:0] exp_rd);
        int waited;
        @(negedge clk);
        sv_enable = sv; host_req = 1'b1; host_we = we;
        host_addr = addr; host_wdata = wd; host_be = be;
        @(negedge clk);
        host_req = 1'b0;
        chk({tag, " R2 busy after accept"}, 32'(host_busy), 32'd1);
        if (sv_flip) sv_enable = ~sv;
        if (poke) begin
            host_req = 1'b1; host_we = ~we; host_addr = 12'h7FC;
            host_wdata = ~wd; host_be = ~be;
            @(negedge clk);
            host_req = 1'b0;
        end
        for (int i = 0; i < n_req; i++) begin
            wait_valid(waited);
            if (i > 0)
                chk({tag, " R8 idle gap >= limit"},
                    32'(waited >= GAP_CFG), 32'd1);
            chk({tag, " R3 addr"},  32'(lnk_req_addr),  32'(addr));
            chk({tag, " R3 wdata"}, lnk_req_wdata,      wd);
            chk({tag, " R3 be"},    32'(lnk_req_be),    32'(be));
            chk({tag, " R3 we"},    32'(lnk_req_we),    32'(we));
            lnk_req_ready = 1'b1;
            @(negedge clk);
            lnk_req_ready = 1'b0;
            repeat (2) @(negedge clk);
            cpl_valid  = 1'b1;
            cpl_status = (i < n_crs) ? 3'd2 : fin_st;
            cpl_data   = (i < n_crs) ? 32'hDEAD_0000 : fin_data;
            @(negedge clk);
            cpl_valid = 1'b0;
            if (i < n_req - 1)
                chk({tag, " R10 no ack on reissue"}, 32'(host_ack), 32'd0);
        end
        chk({tag, " R4 ack"},    32'(host_ack),    32'd1);
        chk({tag, " status"},    32'(host_status), 32'(exp_st));
        chk({tag, " R10 crs"},   32'(host_crs),    32'(exp_crs));
        chk({tag, " rdata"},     host_rdata,       exp_rd);
        @(negedge clk);
        chk({tag, " R10 ack single"}, 32'(host_ack),  32'd0);
        chk({tag, " R2 busy ends"},   32'(host_busy), 32'd0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk({tag, " R2 no extra request"}, 32'(lnk_req_valid), 32'd0);
        end
        sv_enable = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(host_busy), 32'd0);
        chk("R1 ack",  32'(host_ack),  32'd0);
        chk("R1 crs",  32'(host_crs),  32'd0);
        chk("R1 valid", 32'(lnk_req_valid), 32'd0);
    endtask

    task automatic t_read_pass();   // R4
        run_txn("R4 read", 1'b0, 12'h010, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0,
                1, 0, 3'd0, 32'h1234_5678, 3'd0, 1'b0, 32'h1234_5678);
    endtask

    task automatic t_write_ur();    // R4
        run_txn("R4 write ur", 1'b1, 12'h044, 32'hCAFE_F00D, 4'h3, 1'b0,
                1'b0, 1'b0, 1, 0, 3'd1, 32'h5555_5555, 3'd1, 1'b0, 32'h0);
    endtask

    task automatic t_sv_off_retry(); // R5
        run_txn("R5 sv off", 1'b0, 12'h000, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0,
                3, 2, 3'd0, 32'h8086_1AF4, 3'd0, 1'b0, 32'h8086_1AF4);
    endtask

    task automatic t_sv_vid();      // R6
        run_txn("R6 vid subst", 1'b0, 12'h002, 32'h0, 4'hF, 1'b1, 1'b0,
                1'b0, 1, 1, 3'd0, 32'h0, 3'd0, 1'b0, 32'hFFFF_0001);
    endtask

    task automatic t_sv_write0();   // R7
        run_txn("R7 write dw0", 1'b1, 12'h000, 32'hA5A5_A5A5, 4'hF, 1'b1,
                1'b0, 1'b0, 2, 1, 3'd0, 32'h0, 3'd0, 1'b0, 32'h0);
    endtask

    task automatic t_sv_read_other(); // R7
        run_txn("R7 read dw2", 1'b0, 12'h008, 32'h0, 4'hF, 1'b1, 1'b0,
                1'b0, 2, 1, 3'd0, 32'h0604_0001, 3'd0, 1'b0, 32'h0604_0001);
    endtask

    task automatic t_limit_read();  // R9
        retry_limit = 8'd2;
        run_txn("R9 limit read", 1'b0, 12'h00C, 32'h0, 4'hF, 1'b0, 1'b0,
                1'b0, 3, 3, 3'd0, 32'h0, 3'd2, 1'b1, 32'hFFFF_FFFF);
        retry_limit = 8'd5;
    endtask

    task automatic t_limit_write(); // R9
        retry_limit = 8'd0;
        run_txn("R9 limit write", 1'b1, 12'h100, 32'h1, 4'h1, 1'b1, 1'b0,
                1'b0, 1, 1, 3'd0, 32'h0, 3'd2, 1'b1, 32'h0);
        retry_limit = 8'd5;
    endtask

    task automatic t_sv_sampled();  // R11
        run_txn("R11 sv set then cleared", 1'b0, 12'h000, 32'h0, 4'hF,
                1'b1, 1'b1, 1'b0, 1, 1, 3'd0, 32'h0, 3'd0, 1'b0,
                32'hFFFF_0001);
        run_txn("R11 sv clear then set", 1'b0, 12'h000, 32'h0, 4'hF,
                1'b0, 1'b1, 1'b0, 2, 1, 3'd0, 32'h1111_2222, 3'd0, 1'b0,
                32'h1111_2222);
    endtask

    task automatic t_busy_ignore(); // R2
        run_txn("R2 stray request", 1'b0, 12'h020, 32'h0, 4'hC, 1'b0, 1'b0,
                1'b1, 2, 1, 3'd4, 32'h7777_0000, 3'd4, 1'b0, 32'h7777_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_pass();
        t_write_ur();
        t_sv_off_retry();
        t_sv_vid();
        t_sv_write0();
        t_sv_read_other();
        t_limit_read();
        t_limit_write();
        t_sv_sampled();
        t_busy_ignore();
        report();
        $finish;
    end

endmodule